// File: doc/BRIEF.md
# Hardware Spinlock Semaphore Bank

This block is a register-mapped bank of mutual-exclusion locks. Several bus masters or subsystems share it and use it to guard short critical sections. Each lock has a token register. A read of the token register is an atomic test-and-set: it returns zero when the lock was free and takes the lock on that same access. A read that returns a nonzero code means another master already holds the lock. To release a lock, the holder writes one specific 32-bit key to the token register. Any other value written there is discarded.

A sideband input carries the ID of the requesting master. When recording is switched on in the control register, the bank stores that ID at the moment of acquisition. The stored ID can be read back from a per-lock holder register, so software can tell which master owns a contested lock. Every access completes in one cycle. Read data is registered and shows on the cycle after the read.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock is free, every holder register reads 0 and recording is off (the control register reads 0).
- R2: A read of the token register of lock i (byte offset 0x800 + 4*i) returns 0 when lock i is free, and lock i is taken from the next cycle on.
- R3: A read of the token register of a taken lock returns the busy code 0x00000001. The lock stays taken and its holder register is unchanged.
- R4: A write of exactly 0x55AA10C5 to the token register of lock i frees lock i.
- R5: A write of any other value to a token register has no effect on the lock.
- R6: With recording on, the holder register of lock i (byte offset 0x80 + 4*i) reads the master ID, zero-extended, that was on the sideband when lock i was acquired.
- R7: With recording off, an acquisition leaves the holder register at its previous value.
- R8: The control register at byte offset 0x4 stores written bit 0 as the recording enable and reads it back in bit 0. All of its other bits read 0.
- R9: Reads of unmapped or non-word-aligned offsets return 0. Writes to such offsets change nothing.
- R10: Read data is valid on the cycle after the read and is 0 on every other cycle. An access changes at most the one lock it addresses, and locks are independent of each other.
- R11: When read and write strobes are both high in one cycle, only the write is performed. The read takes no lock and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | ID_W (8) | ID of the requesting master |
| bus_rdata | output | 32 | Registered read data, valid on the cycle after a read |

## Verification
The bound checker watches several rules on every cycle:
- A token read of a free lock returns 0 and sets that lock, and a token read of a taken lock returns the busy code.
- A key write clears the addressed lock.
- No lock is set without a token read, and no lock is cleared without a key write.
- At most one lock changes state per cycle.
- Holder IDs stay frozen while recording is off.
- Unmapped reads return zero.

The bench scenarios show what no single-cycle property can. These are the holder IDs read back after a chain of acquire, release and reacquire, the control register field behaviour, the collision of both strobes, and a return to the reset state in the middle of a run.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
    // Value that frees a lock when written to its token register
    localparam logic [31:0] RELEASE_KEY = 32'h55AA10C5;
    // Value returned by a token read that finds the lock taken
    localparam logic [31:0] BUSY_CODE   = 32'h0000_0001;

    // Register map byte offsets
    localparam int CTRL_OFS    = 'h004;
    localparam int HOLDER_BASE = 'h080;
    localparam int TOKEN_BASE  = 'h800;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_CTRL,
        KIND_HOLDER,
        KIND_TOKEN
    } reg_kind_e;
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = NUM_LOCKS * 4;

    logic [ADDR_W-1:0] tok_off;
    logic [ADDR_W-1:0] hld_off;
    logic              in_tok;
    logic              in_hld;
    logic              aligned;

    always_comb begin
        tok_off = addr - ADDR_W'(TOKEN_BASE);
        hld_off = addr - ADDR_W'(HOLDER_BASE);
        aligned = (addr[1:0] == 2'b00);
        in_tok  = (addr >= ADDR_W'(TOKEN_BASE))  && (tok_off < ADDR_W'(SPAN));
        in_hld  = (addr >= ADDR_W'(HOLDER_BASE)) && (hld_off < ADDR_W'(SPAN));
        kind    = KIND_NONE;
        idx     = '0;
        if (aligned) begin
            if (addr == ADDR_W'(CTRL_OFS)) begin
                kind = KIND_CTRL;
            end else if (in_tok) begin
                kind = KIND_TOKEN;
                idx  = tok_off[IDX_W+1:2];
            end else if (in_hld) begin
                kind = KIND_HOLDER;
                idx  = hld_off[IDX_W+1:2];
            end
        end
    end
endmodule

// File: rtl/hwlock_slot.sv
module hwlock_slot #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acquire_req,
    input  logic            release_req,
    input  logic            rec_en,
    input  logic [ID_W-1:0] req_id,
    output logic            taken,
    output logic [ID_W-1:0] holder
);
    typedef struct packed {
        logic            taken;
        logic [ID_W-1:0] holder;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_req) begin
            st_d.taken = 1'b0;
        end else if (acquire_req && !st_q.taken) begin
            st_d.taken = 1'b1;
            if (rec_en) begin
                st_d.holder = req_id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken  = st_q.taken;
    assign holder = st_q.holder;
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ID_W      = 8,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic [ID_W-1:0]   bus_mid,
    output logic [31:0]       bus_rdata
);
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

    typedef struct packed {
        logic        rec_en;
        logic [31:0] rdata;
    } top_t;

    top_t              top_d, top_q;
    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              rd_only;
    logic              rec_en;
    logic [NUM_LOCKS-1:0] acq_vec;
    logic [NUM_LOCKS-1:0] rel_vec;
    logic [NUM_LOCKS-1:0] lock_taken;
    logic [ID_W-1:0]      holder_a [NUM_LOCKS];
    logic [NUM_LOCKS*ID_W-1:0] holder_flat;

    hwlock_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_LOCKS(NUM_LOCKS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr(bus_addr),
        .kind(kind),
        .idx (idx)
    );

    assign rd_only = bus_rd && !bus_wr;
    assign rec_en  = top_q.rec_en;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_slot
        assign acq_vec[g] = rd_only && (kind == KIND_TOKEN) && (idx == IDX_W'(g));
        assign rel_vec[g] = bus_wr && (kind == KIND_TOKEN) && (idx == IDX_W'(g))
                            && (bus_wdata == RELEASE_KEY);
        hwlock_slot #(.ID_W(ID_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .acquire_req(acq_vec[g]),
            .release_req(rel_vec[g]),
            .rec_en     (rec_en),
            .req_id     (bus_mid),
            .taken      (lock_taken[g]),
            .holder     (holder_a[g])
        );
        assign holder_flat[g*ID_W +: ID_W] = holder_a[g];
    end

    always_comb begin
        top_d       = top_q;
        top_d.rdata = '0;
        if (bus_wr && (kind == KIND_CTRL)) begin
            top_d.rec_en = bus_wdata[0];
        end
        if (rd_only) begin
            case (kind)
                KIND_CTRL:   top_d.rdata = {31'b0, top_q.rec_en};
                KIND_HOLDER: top_d.rdata = 32'(holder_a[idx]);
                KIND_TOKEN:  top_d.rdata = lock_taken[idx] ? BUSY_CODE : 32'h0;
                default:     top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ID_W      = 8,
    parameter int ADDR_W    = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic                      rec_en,
    input logic [NUM_LOCKS-1:0]      lock_taken,
    input logic [NUM_LOCKS*ID_W-1:0] holder_flat
);
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
    localparam int SPAN  = NUM_LOCKS * 4;

    logic [ADDR_W-1:0] t_off, h_off;
    logic              tok_hit, mapped, rd_only, key_wr;
    logic [IDX_W-1:0]  tidx;

    always_comb begin
        t_off   = bus_addr - ADDR_W'(TOKEN_BASE);
        h_off   = bus_addr - ADDR_W'(HOLDER_BASE);
        tok_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= ADDR_W'(TOKEN_BASE))
                  && (t_off < ADDR_W'(SPAN));
        mapped  = tok_hit || ((bus_addr[1:0] == 2'b00) && (bus_addr >= ADDR_W'(HOLDER_BASE))
                  && (h_off < ADDR_W'(SPAN))) || (bus_addr == ADDR_W'(CTRL_OFS));
        tidx    = t_off[IDX_W+1:2];
        rd_only = bus_rd && !bus_wr;
        key_wr  = bus_wr && tok_hit && (bus_wdata == RELEASE_KEY);
    end

    assert_free_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && tok_hit && !lock_taken[tidx]) |=> (bus_rdata == 32'h0 && lock_taken[$past(tidx)]));

    assert_busy_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && tok_hit && lock_taken[tidx]) |=> (bus_rdata == BUSY_CODE));

    assert_key_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> !lock_taken[$past(tidx)]);

    assert_no_stray_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> ((~lock_taken & $past(lock_taken)) == '0));

    assert_set_only_by_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_only && tok_hit) |=> ((lock_taken & ~$past(lock_taken)) == '0));

    assert_holder_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(holder_flat));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && !mapped) |=> (bus_rdata == 32'h0));

    assert_one_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_taken ^ $past(lock_taken)) <= 1);
endmodule

bind hwlock_bank hwlock_bank_chk #(
    .NUM_LOCKS(NUM_LOCKS),
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rec_en     (rec_en),
    .lock_taken (lock_taken),
    .holder_flat(holder_flat)
);

// File: tb/tb_hwlock_bank.sv
`timescale 1ns/1ps
module tb_hwlock_bank;
    localparam logic [31:0] KEY = 32'h55AA10C5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_mid = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hwlock_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_mid(bus_mid), .bus_rdata(bus_rdata)
    );

    // op: 1 read, 2 write, 3 both strobes
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [7:0]  mid;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 12'h004, 32'h0,        8'h00, 32'h0},  // R1 control reads 0
        '{2'd1, 12'h080, 32'h0,        8'h00, 32'h0},  // R1 holder 0 reads 0
        '{2'd2, 12'h004, 32'hFFFFFFFF, 8'h00, 32'h0},  // R8 enable recording
        '{2'd1, 12'h004, 32'h0,        8'h00, 32'h1},  // R8 only bit 0 reads back
        '{2'd1, 12'h800, 32'h0,        8'h05, 32'h0},  // R2 free lock 0 taken by 5
        '{2'd1, 12'h800, 32'h0,        8'h09, 32'h1},  // R3 busy
        '{2'd1, 12'h080, 32'h0,        8'h00, 32'h5},  // R6 R3 holder still 5
        '{2'd2, 12'h800, 32'h12345678, 8'h00, 32'h0},  // R5 wrong value
        '{2'd1, 12'h800, 32'h0,        8'h09, 32'h1},  // R5 still busy
        '{2'd2, 12'h800, KEY,          8'h00, 32'h0},  // R4 release
        '{2'd1, 12'h800, 32'h0,        8'h07, 32'h0},  // R4 free again, taken by 7
        '{2'd1, 12'h080, 32'h0,        8'h00, 32'h7},  // R6 new holder
        '{2'd1, 12'h87C, 32'h0,        8'h03, 32'h0},  // R10 last lock independent
        '{2'd1, 12'h0FC, 32'h0,        8'h00, 32'h3},  // R6 last holder
        '{2'd1, 12'h804, 32'h0,        8'h04, 32'h0},  // R10 lock 1 taken by 4
        '{2'd2, 12'h004, 32'h0,        8'h00, 32'h0},  // R8 disable recording
        '{2'd2, 12'h804, KEY,          8'h00, 32'h0},  // R4 release lock 1
        '{2'd1, 12'h804, 32'h0,        8'h22, 32'h0},  // R7 taken without recording
        '{2'd1, 12'h084, 32'h0,        8'h00, 32'h4},  // R7 holder kept
        '{2'd1, 12'h900, 32'h0,        8'h00, 32'h0},  // R9 unmapped read
        '{2'd2, 12'h802, KEY,          8'h00, 32'h0},  // R9 misaligned write
        '{2'd1, 12'h800, 32'h0,        8'h01, 32'h1},  // R9 lock 0 still held
        '{2'd1, 12'h100, 32'h0,        8'h00, 32'h0}   // R9 past holder range
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive one access at a falling edge; data registered at the next rising edge
    task automatic access(input logic [1:0] op, input logic [11:0] a,
                          input logic [31:0] wd, input logic [7:0] m);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = wd;
        bus_mid   = m;
        bus_rd    = op[0];
        bus_wr    = op[1];
        @(negedge clk);
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 rdata idle after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].op, TBL[i].addr, TBL[i].wdata, TBL[i].mid);
            check($sformatf("table step %0d", i), bus_rdata, TBL[i].exp);
        end

        // R10: read data lasts one cycle only
        access(2'd1, 12'h800, 32'h0, 8'h01);
        check("R10 busy read", bus_rdata, 32'h1);
        @(negedge clk);
        check("R10 rdata cleared on idle", bus_rdata, 32'h0);

        // R11: both strobes, the write releases lock 0 and the read is dropped
        access(2'd3, 12'h800, KEY, 8'h01);
        check("R11 collided read returns 0", bus_rdata, 32'h0);
        access(2'd1, 12'h800, 32'h0, 8'h11);
        check("R11 lock freed by write", bus_rdata, 32'h0);
        // R11: both strobes on free lock 2 with wrong value, no acquisition
        access(2'd3, 12'h808, 32'h0, 8'h01);
        access(2'd1, 12'h808, 32'h0, 8'h01);
        check("R11 lock 2 untouched", bus_rdata, 32'h0);
        access(2'd1, 12'h080, 32'h0, 8'h00);
        check("R7 holder 0 kept at 7", bus_rdata, 32'h7);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(2'd1, 12'h004, 32'h0, 8'h00);
        check("R1 recording off", bus_rdata, 32'h0);
        access(2'd1, 12'h0FC, 32'h0, 8'h00);
        check("R1 holder 31 cleared", bus_rdata, 32'h0);
        access(2'd1, 12'h87C, 32'h0, 8'h00);
        check("R1 lock 31 free", bus_rdata, 32'h0);
        access(2'd1, 12'h084, 32'h0, 8'h00);
        check("R1 holder 1 cleared", bus_rdata, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule